// File: doc/BRIEF.md
# AES Single-Round Execution Unit

This unit performs exactly one AES round per issued operation, in the style of a processor's AES instruction extension. Each issue carries a 128-bit state operand, a 128-bit round-key operand and an 8-bit operation code. The unit returns a 128-bit result one clock later. Five operations are provided:

- a full encryption round;
- a last encryption round without column mixing;
- a full decryption round in equivalent-inverse-cipher order;
- a last decryption round;
- a key-preparation operation that applies only inverse column mixing to the state operand.

Software chains ten issues to encrypt or decrypt one AES-128 block. The round keys come from elsewhere. For decryption, the middle round keys are first passed through the key-preparation operation.

Bytes are numbered 0 to 15. Byte 0 sits in the most significant eight bits of each 128-bit port. A byte index splits into a column (index / 4) and a row (index mod 4). The substitution boxes are computed from GF(2^8) inversion and an affine map, so no stored tables are used. Any opcode outside the five is flagged as illegal and yields a zero result.

Top module: `aes_round_unit`

## Requirements
- R1: Byte k of any 128-bit port occupies bits [127-8k : 120-8k]; byte k belongs to column k/4 and row k%4.
- R2: Opcode 0xDC: the result is SubBytes of the row-shifted state (result byte k taken from input byte 4*((k/4 + k%4) mod 4) + k%4), then MixColumns on each column, XOR the key.
- R3: Opcode 0xDD: the same row shift and SubBytes as R2, XOR the key, with no column mixing.
- R4: Opcode 0xDE: inverse row shift (source byte 4*((k/4 - k%4) mod 4) + k%4), then InvSubBytes, then InvMixColumns, and the key XOR is applied last.
- R5: Opcode 0xDF: inverse row shift and InvSubBytes, XOR the key, with no column mixing.
- R6: Opcode 0xDB: InvMixColumns applied to each column of the state operand alone; the key operand has no effect on the result.
- R7: out_valid is high in the cycle after each cycle with in_valid high, and low otherwise; back-to-back issues each produce their own result.
- R8: An issued opcode other than 0xDB..0xDF gives out_result of zero with out_illegal high for that output cycle; a legal opcode gives out_illegal low.
- R9: While in_valid is low, out_result keeps its last value.
- R10: While rst is high and after it, until the first issue, out_valid, out_illegal and out_result are all zero.
- R11: Chaining an initial key XOR, nine 0xDC rounds and one 0xDD round with the AES-128 schedule of key 000102..0f maps plaintext 00112233..eeff to 69c4e0d86a7b0430d8cdb78070b4c55a. The matching 0xDE/0xDF chain, with 0xDB-prepared keys, maps that ciphertext back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the operands below |
| in_op | input | 8 | Operation code |
| in_state | input | 128 | State operand, byte 0 in the top bits |
| in_key | input | 128 | Round-key operand (ignored by 0xDB) |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| out_result | output | 128 | Registered round result |
| out_illegal | output | 1 | Issued opcode was not one of the five |

## Verification
The checker assumes that in_op and the operands are meaningful only in cycles where in_valid is high. It also assumes that reset is held for at least one clock before any issue. The opcode properties are therefore qualified by in_valid, and the hold property only requires the result to stay put across idle cycles. The bench drives every operand at the falling edge, keeps in_valid low throughout reset, and lowers in_valid between directed issues except where back-to-back issue is the point of the test.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int N_COLS    = 4;
    localparam int N_BYTES   = COL_BYTES * N_COLS;
    localparam int COL_W     = BYTE_W * COL_BYTES;
    localparam int STATE_W   = BYTE_W * N_BYTES;
    localparam int OP_W      = 8;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [COL_W-1:0]   col_t;
    typedef logic [STATE_W-1:0] state_t;

    typedef enum logic [OP_W-1:0] {
        OP_IMC      = 8'hDB,
        OP_ENC      = 8'hDC,
        OP_ENC_LAST = 8'hDD,
        OP_DEC      = 8'hDE,
        OP_DEC_LAST = 8'hDF
    } aes_op_e;

    typedef struct packed {
        logic   valid;
        logic   illegal;
        state_t data;
    } round_reg_t;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse; zero maps to zero
    function automatic byte_t gf_inv(byte_t a);
        byte_t p2, p4, p8, p16, p32, p64, p128;
        p2   = gf_mul(a, a);
        p4   = gf_mul(p2, p2);
        p8   = gf_mul(p4, p4);
        p16  = gf_mul(p8, p8);
        p32  = gf_mul(p16, p16);
        p64  = gf_mul(p32, p32);
        p128 = gf_mul(p64, p64);
        return gf_mul(gf_mul(gf_mul(p2, p4), gf_mul(p8, p16)),
                      gf_mul(gf_mul(p32, p64), p128));
    endfunction

    function automatic byte_t rotl8(byte_t a, int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t affine_fwd(byte_t b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic byte_t affine_rev(byte_t b);
        return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
    endfunction

    // one column, row 0 in the top byte
    function automatic col_t mix_fwd(col_t c);
        byte_t a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {gf_mul(a0, 8'h02) ^ gf_mul(a1, 8'h03) ^ a2 ^ a3,
                a0 ^ gf_mul(a1, 8'h02) ^ gf_mul(a2, 8'h03) ^ a3,
                a0 ^ a1 ^ gf_mul(a2, 8'h02) ^ gf_mul(a3, 8'h03),
                gf_mul(a0, 8'h03) ^ a1 ^ a2 ^ gf_mul(a3, 8'h02)};
    endfunction

    function automatic col_t mix_rev(col_t c);
        byte_t a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {gf_mul(a0, 8'h0E) ^ gf_mul(a1, 8'h0B) ^ gf_mul(a2, 8'h0D) ^ gf_mul(a3, 8'h09),
                gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0E) ^ gf_mul(a2, 8'h0B) ^ gf_mul(a3, 8'h0D),
                gf_mul(a0, 8'h0D) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0E) ^ gf_mul(a3, 8'h0B),
                gf_mul(a0, 8'h0B) ^ gf_mul(a1, 8'h0D) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0E)};
    endfunction

endpackage

// File: rtl/aes_byte_sbox.sv
module aes_byte_sbox
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  byte_t din,
    output byte_t dout
);
    generate
        if (INVERSE) begin : g_rev
            assign dout = gf_inv(affine_rev(din));
        end else begin : g_fwd
            assign dout = affine_fwd(gf_inv(din));
        end
    endgenerate
endmodule

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  state_t din,
    output state_t dout
);
    generate
        for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
            localparam int HI = STATE_W - 1 - BYTE_W * k;
            aes_byte_sbox #(.INVERSE(INVERSE)) u_sb (
                .din  (din[HI -: BYTE_W]),
                .dout (dout[HI -: BYTE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/aes_row_perm.sv
module aes_row_perm
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  state_t din,
    output state_t dout
);
    generate
        for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
            localparam int ROW     = k % COL_BYTES;
            localparam int COL     = k / COL_BYTES;
            localparam int SRC_COL = INVERSE ? (COL + N_COLS - ROW) % N_COLS
                                             : (COL + ROW) % N_COLS;
            localparam int SRC     = SRC_COL * COL_BYTES + ROW;
            assign dout[STATE_W - 1 - BYTE_W * k -: BYTE_W] =
                   din[STATE_W - 1 - BYTE_W * SRC -: BYTE_W];
        end
    endgenerate
endmodule

// File: rtl/aes_col_mix_bank.sv
module aes_col_mix_bank
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  state_t din,
    output state_t dout
);
    generate
        for (genvar c = 0; c < N_COLS; c++) begin : g_col
            localparam int HI = STATE_W - 1 - COL_W * c;
            if (INVERSE) begin : g_rev
                assign dout[HI -: COL_W] = mix_rev(din[HI -: COL_W]);
            end else begin : g_fwd
                assign dout[HI -: COL_W] = mix_fwd(din[HI -: COL_W]);
            end
        end
    endgenerate
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
    import aes_rnd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [7:0]   in_op,
    input  logic [127:0] in_state,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_result,
    output logic         out_illegal
);
    state_t shf_enc, sub_enc, mix_enc;
    state_t shf_dec, sub_dec, imix_in, imix_out;
    state_t nxt_data;
    logic   nxt_illegal;
    round_reg_t q;

    // encryption path
    aes_row_perm #(.INVERSE(1'b0)) u_shf_enc (.din(in_state), .dout(shf_enc));
    aes_sbox_bank #(.INVERSE(1'b0)) u_sub_enc (.din(shf_enc), .dout(sub_enc));
    aes_col_mix_bank #(.INVERSE(1'b0)) u_mix_enc (.din(sub_enc), .dout(mix_enc));

    // decryption path; the inverse mixer is shared with key preparation
    aes_row_perm #(.INVERSE(1'b1)) u_shf_dec (.din(in_state), .dout(shf_dec));
    aes_sbox_bank #(.INVERSE(1'b1)) u_sub_dec (.din(shf_dec), .dout(sub_dec));

    assign imix_in = (in_op == OP_IMC) ? in_state : sub_dec;

    aes_col_mix_bank #(.INVERSE(1'b1)) u_mix_dec (.din(imix_in), .dout(imix_out));

    always_comb begin
        nxt_illegal = 1'b0;
        case (aes_op_e'(in_op))
            OP_IMC:      nxt_data = imix_out;
            OP_ENC:      nxt_data = mix_enc ^ in_key;
            OP_ENC_LAST: nxt_data = sub_enc ^ in_key;
            OP_DEC:      nxt_data = imix_out ^ in_key;
            OP_DEC_LAST: nxt_data = sub_dec ^ in_key;
            default: begin
                nxt_data    = '0;
                nxt_illegal = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid   <= in_valid;
            q.illegal <= in_valid & nxt_illegal;
            if (in_valid) q.data <= nxt_data;
        end
    end

    assign out_valid   = q.valid;
    assign out_illegal = q.illegal;
    assign out_result  = q.data;
endmodule

// File: rtl/aes_round_unit_chk.sv
module aes_round_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [7:0]   in_op,
    input logic         out_valid,
    input logic [127:0] out_result,
    input logic         out_illegal
);
    // R7
    issue_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_gives_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    illegal_means_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_valid && out_result == 128'd0));

    // R8
    bad_op_flagged_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op < 8'hDB || in_op > 8'hDF)) |=> out_illegal);

    // R8
    good_op_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op >= 8'hDB && in_op <= 8'hDF) |=> !out_illegal);

    // R9
    idle_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
endmodule

bind aes_round_unit aes_round_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/sim_aes_round_unit.sv
module sim_aes_round_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [7:0]   in_op = 8'h00;
    logic [127:0] in_state = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] sb [256];

    always #5 clk = ~clk;

    aes_round_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_state(in_state), .in_key(in_key),
        .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
    );

    typedef struct packed {
        logic [7:0]   op;
        logic [127:0] st;
        logic [127:0] key;
        logic [127:0] exp;
        logic         ill;
        logic [3:0]   req;
    } vec_t;

    localparam logic [127:0] KA = 128'h0123456789abcdeffedcba9876543210;
    localparam logic [127:0] S63 = {16{8'h63}};
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R6 known InvMixColumns columns, key zero
        '{8'hDB, 128'h8e4da1bc9fdc589d01010101c6c6c6c6, 128'd0,
          128'hdb135345f20a225c01010101c6c6c6c6, 1'b0, 4'd6},
        // R6 same state, all-ones key must not change the result
        '{8'hDB, 128'h8e4da1bc9fdc589d01010101c6c6c6c6, {128{1'b1}},
          128'hdb135345f20a225c01010101c6c6c6c6, 1'b0, 4'd6},
        // R6 further columns with a nonzero key
        '{8'hDB, 128'h046681e5d5d5d7d64d7ebdf8c6c6c6c6, KA,
          128'hd4bf5d30d4d4d4d52d26314cc6c6c6c6, 1'b0, 4'd6},
        // R2 zero state: every byte becomes 0x63, mixing keeps it
        '{8'hDC, 128'd0, 128'd0, S63, 1'b0, 4'd2},
        // R2 key XOR last
        '{8'hDC, 128'd0, KA, S63 ^ KA, 1'b0, 4'd2},
        // R3
        '{8'hDD, 128'd0, 128'd0, S63, 1'b0, 4'd3},
        // R4 inverse substitution of 0x63 is zero
        '{8'hDE, S63, 128'd0, 128'd0, 1'b0, 4'd4},
        // R4 key applied after inverse mixing
        '{8'hDE, S63, KA, KA, 1'b0, 4'd4},
        // R5
        '{8'hDF, S63, KA, KA, 1'b0, 4'd5},
        // R8 illegal opcodes
        '{8'h00, S63, KA, 128'd0, 1'b1, 4'd8},
        '{8'hDA, S63, KA, 128'd0, 1'b1, 4'd8},
        '{8'hE0, S63, KA, 128'd0, 1'b1, 4'd8},
        '{8'hFF, S63, KA, 128'd0, 1'b1, 4'd8}
    };

    function automatic logic [7:0] tmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'd0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return r;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one operation, return the registered outputs of the next cycle
    task automatic issue(input logic [7:0] op, input logic [127:0] st, input logic [127:0] key,
                         output logic [127:0] res, output logic ill, output logic vld);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_state = st; in_key = key;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_result; ill = out_illegal; vld = out_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [127:0] res, exp, st, pt, ct;
        logic ill, vld;
        logic [31:0] w [44];
        logic [127:0] rk [11];
        logic [127:0] dk [11];
        logic [7:0] rc;

        // bench S-box: brute-force inverse then affine map
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv, s;
            inv = 8'd0;
            for (int y = 1; y < 256; y++)
                if (tmul(8'(x), 8'(y)) == 8'd1) inv = 8'(y);
            for (int k = 0; k < 8; k++)
                s[k] = inv[k] ^ inv[(k+4)%8] ^ inv[(k+5)%8] ^ inv[(k+6)%8] ^ inv[(k+7)%8] ^ 8'h63 >> k;
            sb[x] = s;
        end

        // R10 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_illegal == 1'b0, "R10 flags in reset",
              {126'd0, out_valid, out_illegal}, 128'd0);
        check(out_result == 128'd0, "R10 result in reset", out_result, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_result == 128'd0, "R10 after release", out_result, 128'd0);

        // table walk (R2 R3 R4 R5 R6 R8)
        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].op, VECS[v].st, VECS[v].key, res, ill, vld);
            check(res == VECS[v].exp, $sformatf("R%0d vector %0d result", VECS[v].req, v),
                  res, VECS[v].exp);
            check(ill == VECS[v].ill && vld == 1'b1, $sformatf("R%0d vector %0d flags", VECS[v].req, v),
                  {126'd0, vld, ill}, {126'd0, 1'b1, VECS[v].ill});
        end

        // R1 R3 byte placement through row shift: byte k = k
        st = 128'h000102030405060708090a0b0c0d0e0f;
        for (int k = 0; k < 16; k++) begin
            int src;
            src = 4 * (((k / 4) + (k % 4)) % 4) + (k % 4);
            exp[127 - 8*k -: 8] = sb[src];
        end
        issue(8'hDD, st, 128'd0, res, ill, vld);
        check(res == exp, "R1 R3 shifted substitution", res, exp);
        // R5 last decrypt round undoes it
        issue(8'hDF, res, 128'd0, res, ill, vld);
        check(res == st, "R5 inverse of last encrypt round", res, st);

        // R9 hold while idle
        repeat (3) @(negedge clk);
        check(out_result == st && out_valid == 1'b0, "R9 result held", out_result, st);

        // R7 back-to-back issues
        @(negedge clk);
        in_valid = 1'b1; in_op = 8'hDD; in_state = 128'd0; in_key = 128'd0;
        @(negedge clk);
        in_op = 8'hDB; in_state = 128'h8e4da1bc9fdc589d01010101c6c6c6c6; in_key = KA;
        check(out_valid && out_result == S63, "R7 first of pair", out_result, S63);
        @(negedge clk);
        in_valid = 1'b0;
        exp = 128'hdb135345f20a225c01010101c6c6c6c6;
        check(out_valid && out_result == exp, "R7 second of pair", out_result, exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R7 valid drops", {127'd0, out_valid}, 128'd0);

        // R11 key schedule computed in the bench
        for (int i = 0; i < 4; i++) w[i] = 32'(128'h000102030405060708090a0b0c0d0e0f >> (96 - 32*i));
        rc = 8'h01;
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t;
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]] ^ rc, sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
                rc = tmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};

        pt = 128'h00112233445566778899aabbccddeeff;
        ct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        res = pt ^ rk[0];
        for (int r = 1; r < 10; r++) issue(8'hDC, res, rk[r], res, ill, vld);
        issue(8'hDD, res, rk[10], res, ill, vld);
        check(res == ct, "R11 ten-round encryption", res, ct);

        for (int r = 1; r < 10; r++) issue(8'hDB, rk[r], 128'd0, dk[r], ill, vld);
        res = ct ^ rk[10];
        for (int r = 9; r >= 1; r--) issue(8'hDE, res, dk[r], res, ill, vld);
        issue(8'hDF, res, rk[0], res, ill, vld);
        check(res == pt, "R11 R4 ten-round decryption", res, pt);

        // R10 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(out_result == 128'd0 && out_valid == 1'b0 && out_illegal == 1'b0,
              "R10 reset clears result", out_result, 128'd0);
        rst = 1'b0;

        summary();
    end

endmodule